// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

The block gathers a vector of interrupt sources and decides which of them may interrupt the processor. A source is pending when its hardware request input is high or its software pending bit is set. Every source has a 4-bit priority. The controller picks the strongest pending source. It raises the processor interrupt only when that priority is strictly greater than a current-priority level held in a register.

When the processor takes an interrupt, the current level is pushed onto an internal last-in-first-out stack, and the level becomes the priority of the source being served. A write to the end-of-service register pops the stack back into the level. This lets handlers nest without software saving the mask. Software can also move the level up or down directly, which is the basis of a priority-ceiling locking scheme.

The processor can take the interrupt in one of two ways. In software vector mode it reads an acknowledge register that returns a vector word. In hardware vector mode it pulses an acknowledge input and takes the source index from a dedicated output. The spacing of the vector word is selectable.

Top module: `prio_irq_ctrl`

## Requirements
- R1: `cpu_irq_o` is high only when some pending source has a priority strictly greater than the current level. A source with priority equal to or below the level, including any source with priority 0, never raises it.
- R2: Arbitration selects the highest priority among the pending sources. On a tie the lowest source index wins. `cpu_vec_o` shows the winning index, and shows 0 when nothing is pending.
- R3: In software vector mode (config bit 0 = 0), a bus read of offset 0x10 while `cpu_irq_o` is high is an acknowledge. It pushes the level and loads the winner's priority. `cpu_ack_i` has no effect in this mode.
- R4: In hardware vector mode (config bit 0 = 1), `cpu_ack_i` high while `cpu_irq_o` is high is an acknowledge. Reads of 0x10 have no side effect in this mode.
- R5: Any bus write to offset 0x18 pops the stack top into the level. The write data is ignored.
- R6: The level register sits at offset 0x08, in bits [3:0]. Its upper bits read 0. It resets to 15 and is directly writable.
- R7: A read of 0x10 returns the winning index shifted left by 2 when config bit 5 = 0, or by 3 when config bit 5 = 1. All other bits are 0. The read returns 0 when `cpu_irq_o` is low.
- R8: The stack holds 15 entries. An acknowledge when the stack is full, or a pop when it is empty, sets the sticky `err_o`. In both cases the stack and the level stay unchanged.
- R9: A write to offset 0x20 sets software pending bit i from data bit i and clears it from data bit 16+i. Clear wins when both are set. A read of 0x20 returns the pending bits. An acknowledge clears the winner's software bit.
- R10: An acknowledge and a pop in the same cycle act as pop-then-push. With a non-empty stack, the depth is unchanged and the level becomes the winner's priority. With an empty stack, `err_o` is set, the old level is pushed, and the level becomes the winner's priority.
- R11: A direct write of the level in the same cycle as an acknowledge is discarded. The acknowledge result stands.
- R12: The priority of source i is at offset 0x40+4*i, in bits [3:0]. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, valid in the access cycle |
| irq_src_i | input | NSRC (8) | Level-sensitive hardware requests |
| cpu_irq_o | output | 1 | Interrupt to the processor |
| cpu_vec_o | output | IW (3) | Winning source index |
| cpu_ack_i | input | 1 | Processor acknowledge, used in hardware vector mode |
| err_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
In hardware vector mode, the processor acknowledge and an end-of-service bus write can land in the same clock cycle. An acknowledge can also coincide with a direct write of the level. The bench raises `cpu_ack_i` in the very cycle that carries the bus write. It does this once with a stacked level and once with an empty stack. It then reads the level back and watches `err_o`. The reference model applies the pop before the push and drops the direct write. Any difference in the read value, the error flag or the interrupt line is reported on that clock.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  localparam logic [7:0] ADDR_CFG  = 8'h00;
  localparam logic [7:0] ADDR_LVL  = 8'h08;
  localparam logic [7:0] ADDR_IACK = 8'h10;
  localparam logic [7:0] ADDR_EOI  = 8'h18;
  localparam logic [7:0] ADDR_SWP  = 8'h20;
  localparam int unsigned PRIO_BASE = 32'h40;

  localparam int unsigned CFG_HW_BIT  = 0;
  localparam int unsigned CFG_VSZ_BIT = 5;
  localparam int unsigned SWP_CLR_LSB = 16;

  // byte offset of the priority field of source i
  function automatic int unsigned prio_addr(input int unsigned i);
    return PRIO_BASE + 4 * i;
  endfunction

  // acknowledge word: index placed above 2 or 3 zero bits
  function automatic logic [31:0] iack_word(input int unsigned idx, input logic wide);
    return 32'(idx) << (wide ? 3 : 2);
  endfunction

endpackage

// File: rtl/prio_arb.sv
module prio_arb #(
  parameter int NSRC = 8,
  parameter int PW   = 4,
  parameter int IW   = 3
) (
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               any,
  output logic [PW-1:0]      best_pri,
  output logic [IW-1:0]      best_idx
);
  // strict compare keeps the lower index on a tie
  always_comb begin
    any      = 1'b0;
    best_pri = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!any || prio_flat[i*PW +: PW] > best_pri)) begin
        any      = 1'b1;
        best_pri = prio_flat[i*PW +: PW];
        best_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int DEPTH = 15,
  parameter int PW    = 4,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] top,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);
  logic [PW-1:0] mem [DEPTH];
  logic          wr_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign ovf   = push & ~pop & full;
  assign unf   = pop & empty;
  assign top   = empty ? '0 : mem[count - CW'(1)];
  // pop-then-push: only an empty stack takes a write when both are asked
  assign wr_ok = push & (pop ? empty : ~full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push && pop) begin
      if (empty) count <= CW'(1);
    end else if (push && !full) begin
      count <= count + CW'(1);
    end else if (pop && !empty) begin
      count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[count] <= din;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int PW    = 4,
  parameter int DEPTH = 15,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_src_i,
  output logic            cpu_irq_o,
  output logic [IW-1:0]   cpu_vec_o,
  input  logic            cpu_ack_i,
  output logic            err_o
);
  logic              hw_mode, wide_vec, err_q;
  logic [PW-1:0]     cpr_q;
  logic [NSRC-1:0]   sw_pend, sw_nxt, prio_we;
  logic [NSRC*PW-1:0] prio_flat;
  logic              wr_cfg, wr_lvl, wr_swp, iack_rd, ack_ev, eoi_ev;
  logic              push_ok, pop_ok;
  logic              win_any;
  logic [PW-1:0]     win_pri, lifo_top;
  logic [IW-1:0]     win_idx;
  logic [CW-1:0]     lifo_cnt;
  logic              lifo_full, lifo_empty, lifo_ovf, lifo_unf;
  logic [DW-1:0]     rdata_c;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  // register decode
  assign wr_cfg  = bus_sel & bus_wr & (bus_addr == AW'(ADDR_CFG));
  assign wr_lvl  = bus_sel & bus_wr & (bus_addr == AW'(ADDR_LVL));
  assign wr_swp  = bus_sel & bus_wr & (bus_addr == AW'(ADDR_SWP));
  assign eoi_ev  = bus_sel & bus_wr & (bus_addr == AW'(ADDR_EOI));
  assign iack_rd = bus_sel & ~bus_wr & (bus_addr == AW'(ADDR_IACK));

  for (genvar g = 0; g < NSRC; g++) begin : g_prio_we
    assign prio_we[g] = bus_sel & bus_wr & (bus_addr == AW'(prio_addr(g)));
  end

  prio_arb #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_arb (
    .pend      (irq_src_i | sw_pend),
    .prio_flat (prio_flat),
    .any       (win_any),
    .best_pri  (win_pri),
    .best_idx  (win_idx)
  );

  assign cpu_irq_o = win_any & (win_pri > cpr_q);
  assign cpu_vec_o = win_idx;
  assign ack_ev    = cpu_irq_o & (hw_mode ? cpu_ack_i : iack_rd);
  assign push_ok   = ack_ev & (eoi_ev | ~lifo_full);
  assign pop_ok    = eoi_ev & ~lifo_empty & ~ack_ev;

  prio_lifo #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_lifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ack_ev),
    .pop   (eoi_ev),
    .din   (cpr_q),
    .top   (lifo_top),
    .count (lifo_cnt),
    .full  (lifo_full),
    .empty (lifo_empty),
    .ovf   (lifo_ovf),
    .unf   (lifo_unf)
  );

  always_comb begin
    sw_nxt = sw_pend;
    if (wr_swp) sw_nxt = (sw_pend | bus_wdata[NSRC-1:0]) & ~bus_wdata[SWP_CLR_LSB +: NSRC];
    if (push_ok) sw_nxt[win_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpr_q     <= '1;
      hw_mode   <= 1'b0;
      wide_vec  <= 1'b0;
      err_q     <= 1'b0;
      sw_pend   <= '0;
      prio_flat <= '0;
    end else begin
      if (push_ok)               cpr_q <= win_pri;
      else if (pop_ok)           cpr_q <= lifo_top;
      else if (wr_lvl && !ack_ev) cpr_q <= bus_wdata[PW-1:0];
      if (wr_cfg) begin
        hw_mode  <= bus_wdata[CFG_HW_BIT];
        wide_vec <= bus_wdata[CFG_VSZ_BIT];
      end
      err_q   <= err_q | lifo_ovf | lifo_unf;
      sw_pend <= sw_nxt;
      for (int i = 0; i < NSRC; i++)
        if (prio_we[i]) prio_flat[i*PW +: PW] <= bus_wdata[PW-1:0];
    end
  end

  assign err_o = err_q;

  always_comb begin
    rdata_c = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == AW'(ADDR_CFG)) begin
        rdata_c[CFG_HW_BIT]  = hw_mode;
        rdata_c[CFG_VSZ_BIT] = wide_vec;
      end
      if (bus_addr == AW'(ADDR_LVL)) rdata_c[PW-1:0] = cpr_q;
      if (bus_addr == AW'(ADDR_IACK) && cpu_irq_o)
        rdata_c = DW'(iack_word(int'(win_idx), wide_vec));
      if (bus_addr == AW'(ADDR_SWP)) rdata_c[NSRC-1:0] = sw_pend;
      for (int i = 0; i < NSRC; i++)
        if (bus_addr == AW'(prio_addr(i))) rdata_c[PW-1:0] = prio_flat[i*PW +: PW];
    end
  end

  assign bus_rdata = rdata_c;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int PW    = 4,
  parameter int DEPTH = 15,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_ev,
  input logic          eoi_ev,
  input logic          cpu_irq,
  input logic [PW-1:0] win_pri,
  input logic [PW-1:0] cpr,
  input logic [CW-1:0] count,
  input logic          err
);
  // R1
  mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> cpr != '1);

  // R3
  ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev && !eoi_ev && count < CW'(DEPTH) |=>
      cpr == $past(win_pri) && count == $past(count) + CW'(1));

  // R5
  eoi_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_ev && !ack_ev && count != '0 |=> count == $past(count) - CW'(1));

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev && !eoi_ev && count == CW'(DEPTH) |=>
      cpr == $past(cpr) && count == $past(count) && err);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R10
  both_ev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ev && eoi_ev && count != '0 |=> count == $past(count) && cpr == $past(win_pri));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.PW(PW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ack_ev  (ack_ev),
  .eoi_ev  (eoi_ev),
  .cpu_irq (cpu_irq_o),
  .win_pri (win_pri),
  .cpr     (cpr_q),
  .count   (lifo_cnt),
  .err     (err_o)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, cpu_ack = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] irq_src = '0;
  logic        cpu_irq, err;
  logic [2:0]  cpu_vec;

  int    nvec = 0, nfail = 0;
  string cur_req = "R6";

  // reference state
  int    m_cpr;
  int    m_stk[$];
  bit    m_err, m_hw, m_wide;
  int    m_prio[N];
  bit [N-1:0] m_sw;

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_src_i(irq_src), .cpu_irq_o(cpu_irq), .cpu_vec_o(cpu_vec),
    .cpu_ack_i(cpu_ack), .err_o(err)
  );

  // scan levels from the top; first index found at a level wins
  function automatic void m_win(output bit any, output int idx, output int pri);
    bit [N-1:0] p = irq_src | m_sw;
    any = 0; idx = 0; pri = 0;
    for (int lv = 15; lv >= 0 && !any; lv--)
      for (int s = 0; s < N && !any; s++)
        if (p[s] && m_prio[s] == lv) begin any = 1; idx = s; pri = lv; end
  endfunction

  function automatic bit m_irq();
    bit a; int i, p;
    m_win(a, i, p);
    return a && p > m_cpr;
  endfunction

  function automatic logic [31:0] m_rd(input logic [7:0] a);
    bit an; int i, p;
    m_win(an, i, p);
    if (a == 8'h00) return (32'(m_wide) << 5) | 32'(m_hw);
    if (a == 8'h08) return 32'(m_cpr);
    if (a == 8'h10) return m_irq() ? (32'(i) * (m_wide ? 8 : 4)) : 32'h0;
    if (a == 8'h20) return 32'(m_sw);
    for (int s = 0; s < N; s++) if (a == 8'(64 + 4 * s)) return 32'(m_prio[s]);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cpr = 15; m_stk = {}; m_err = 0; m_hw = 0; m_wide = 0; m_sw = '0;
      for (int s = 0; s < N; s++) m_prio[s] = 0;
    end else begin
      bit an, ack, eoi; int wi, wp;
      m_win(an, wi, wp);
      ack = m_irq() && (m_hw ? cpu_ack : (bus_sel && !bus_wr && bus_addr == 8'h10));
      eoi = bus_sel && bus_wr && bus_addr == 8'h18;
      if (bus_sel && bus_wr) begin
        if (bus_addr == 8'h00) begin m_hw = bus_wdata[0]; m_wide = bus_wdata[5]; end
        if (bus_addr == 8'h08 && !ack) m_cpr = int'(bus_wdata[3:0]);
        if (bus_addr == 8'h20) m_sw = (m_sw | bus_wdata[N-1:0]) & ~bus_wdata[16 +: N];
        for (int s = 0; s < N; s++) if (bus_addr == 8'(64 + 4 * s)) m_prio[s] = int'(bus_wdata[3:0]);
      end
      if (ack && eoi) begin
        if (m_stk.size() == 0) begin m_err = 1; m_stk.push_back(m_cpr); end
        m_cpr = wp; m_sw[wi] = 0;
      end else if (ack) begin
        if (m_stk.size() == 15) m_err = 1;
        else begin m_stk.push_back(m_cpr); m_cpr = wp; m_sw[wi] = 0; end
      end else if (eoi) begin
        if (m_stk.size() == 0) m_err = 1;
        else m_cpr = m_stk.pop_back();
      end
    end
  end

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit an; int wi, wp;
      m_win(an, wi, wp);
      cmp("R1", "cpu_irq_o", 32'(cpu_irq), 32'(m_irq()));
      cmp("R2", "cpu_vec_o", 32'(cpu_vec), an ? 32'(wi) : 32'h0);
      cmp("R8", "err_o", 32'(err), 32'(m_err));
      if (bus_sel && !bus_wr) cmp(cur_req, "bus_rdata", bus_rdata, m_rd(bus_addr));
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic bus(input bit w, input logic [7:0] a, input logic [31:0] d, input bit ack);
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d; cpu_ack = ack;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_wdata = '0; cpu_ack = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d); bus(1, a, d, 0); endtask
  task automatic rd(input logic [7:0] a); bus(0, a, 32'h0, 0); endtask

  task automatic ack_pulse();
    cpu_ack = 1; @(posedge clk); #1; cpu_ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; irq_src = '0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R6";  rd(8'h08);
    cur_req = "R12"; rd(8'h40); rd(8'h5C);
    wr(8'h40, 3); wr(8'h44, 5); wr(8'h48, 5); wr(8'h4C, 9); wr(8'h50, 0); wr(8'h5C, 12);
    rd(8'h4C); rd(8'h5C);
    cur_req = "R6";  wr(8'h08, 32'hFFFF_FFF2); rd(8'h08);
    cur_req = "R1";  irq_src = 8'h01; step(2); wr(8'h08, 3); step(2);
    irq_src = 8'h10; wr(8'h08, 0); step(2); wr(8'h08, 3);
    cur_req = "R2";  irq_src = 8'h06; step(2); irq_src = 8'h0E; step(2);
    cur_req = "R7";  wr(8'h00, 32'h1); rd(8'h10); rd(8'h08);
    wr(8'h00, 32'h21); rd(8'h10); rd(8'h00);
    cur_req = "R4";  ack_pulse(); rd(8'h08);
    irq_src = 8'h8E; step(1); ack_pulse(); rd(8'h08);
    cur_req = "R5";  wr(8'h18, 32'hDEAD_BEEF); rd(8'h08); wr(8'h18, 32'h5); rd(8'h08);
    cur_req = "R3";  wr(8'h00, 32'h0); ack_pulse(); rd(8'h08);
    rd(8'h10); rd(8'h08); wr(8'h18, 0); rd(8'h08);
    cur_req = "R9";  irq_src = '0; wr(8'h20, 32'h21); rd(8'h20);
    wr(8'h20, 32'h0001_0001); rd(8'h20);
    wr(8'h54, 7); step(1); rd(8'h10); rd(8'h20); rd(8'h08); wr(8'h18, 0);
    cur_req = "R8";  rd(8'h08); wr(8'h18, 0); rd(8'h08); step(2);
    do_reset();
    wr(8'h4C, 9); irq_src = 8'h08; wr(8'h00, 32'h1);
    for (int k = 0; k < 15; k++) begin wr(8'h08, 0); ack_pulse(); end
    rd(8'h08); wr(8'h08, 0); ack_pulse(); rd(8'h08); step(1);
    for (int k = 0; k < 15; k++) wr(8'h18, 0);
    rd(8'h08);
    do_reset();
    cur_req = "R10"; wr(8'h4C, 9); wr(8'h5C, 12); wr(8'h00, 32'h1); wr(8'h08, 2);
    irq_src = 8'h08; step(1); ack_pulse(); rd(8'h08);
    irq_src = 8'h88; step(1); bus(1, 8'h18, 0, 1); rd(8'h08);
    wr(8'h18, 0); rd(8'h08);
    irq_src = 8'h08; step(1); bus(1, 8'h18, 0, 1); rd(8'h08); step(1);
    wr(8'h18, 0); rd(8'h08);
    cur_req = "R11"; bus(1, 8'h08, 5, 1); rd(8'h08); wr(8'h18, 0); rd(8'h08);
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule